// File: doc/BRIEF.md
# Sequencer System Stack

This block is the last-in-first-out store of a small DSP sequencer. It holds fifteen rows. Each row has two independent 16-bit halves. The high half carries a return or loop-end address and the low half carries a status word or a loop count. A 6-bit stack pointer names the top row in its low four bits. Its upper two bits are an error flag and an underflow flag. These flags are not set by separate logic: they appear because the whole 6-bit value wraps under ordinary increment and decrement. Whenever either flag is up, a registered critical-error output goes high for the interrupt logic.

The surrounding sequencer drives the block with single-cycle commands. These are a full push of both halves, a pull, a bare pointer step up or down, and a write to one half of the current top row. Two further commands move a value into or out of the high half, and each takes two cycles. A move into the high half steps the pointer first and writes in the second cycle. A move out of the high half reads first and steps the pointer down in the second cycle. Low-half moves never touch the pointer. The pointer is also decoded into a registered one-hot row select. The top row is read back through registered outputs one cycle later.

Top module: `sstk_top`

## Requirements
- R1: A synchronous reset, active high, clears the pointer to 000000, the critical-error output, the row select and both read outputs. Stack contents are left undefined.
- R2: Pointer bits 3..0 index the top row, bit 4 is the error flag and bit 5 the underflow flag. `crit_err_o` is high in exactly the cycles in which bit 4 or bit 5 of `sp_o` is set.
- R3: A push adds one to the 6-bit pointer and writes `hi_din_i` and `lo_din_i` into the row that the new pointer selects. A push at 001111 yields 010000, which selects no row, so nothing is written.
- R4: A pull subtracts one from the 6-bit pointer, and no row is written. A pull at 000000 yields 111111.
- R5: `row_sel_o` is one-hot: a pointer whose low four bits are n (1..15) sets bit n-1, and n = 0 sets no bit. `top_hi_o` and `top_lo_o` show, one cycle later, the row selected in the cycle before, as it was before that cycle's write. When no row is selected they show zero.
- R6: The step-up and step-down commands change only the pointer (by +1 or -1), never the stored rows.
- R7: A move into the high half adds one to the pointer in its first cycle and latches `hi_din_i`. In the second cycle it writes that value to the high half of the new top row. The pointer and the low half are left unchanged.
- R8: A move out of the high half leaves the pointer unchanged in its first cycle, so the top high half appears on `top_hi_o` in the next cycle. The pointer is then decremented in the second cycle.
- R9: A half write stores `hi_din_i` and/or `lo_din_i` into the chosen half of the current top row without changing the pointer.
- R10: When several commands arrive together, one wins in this order: push, pull, move into high, move out of high, step up, step down, half writes. In the second cycle of a two-cycle move, every command input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push both halves |
| pull_i | input | 1 | Pull top row |
| put_hi_i | input | 1 | Two-cycle move into the high half |
| take_hi_i | input | 1 | Two-cycle move out of the high half |
| up_i | input | 1 | Pointer step up |
| down_i | input | 1 | Pointer step down |
| wr_hi_i | input | 1 | Write high half of current top |
| wr_lo_i | input | 1 | Write low half of current top |
| hi_din_i | input | 16 | High-half write data |
| lo_din_i | input | 16 | Low-half write data |
| top_hi_o | output | 16 | Registered high half of top row |
| top_lo_o | output | 16 | Registered low half of top row |
| sp_o | output | 6 | Stack pointer with flags |
| row_sel_o | output | 15 | One-hot row select |
| crit_err_o | output | 1 | Overflow/underflow critical error |

## Verification
The properties assume that every command input is a known 0 or 1 on each rising edge. They also assume that several commands arriving in one cycle are resolved by the stated priority rather than rejected. The pointer checks in the properties are therefore gated on the same priority and on the two-cycle move being idle. The stimulus honours this by driving all inputs on the falling edge only. It deliberately stacks conflicting commands and issues commands inside the second cycle of a move, so the ignore rule is exercised rather than avoided. Rows are read back only after they are written, because their contents after reset are undefined.

// File: rtl/sstk_pkg.sv
package sstk_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_PULL,
    OP_PUT,
    OP_TAKE,
    OP_UP,
    OP_DOWN,
    OP_HALF
  } sstk_op_t;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_PUT2,
    MV_TAKE2
  } sstk_mv_t;
endpackage

// File: rtl/sstk_ptr.sv
module sstk_ptr #(
  parameter int PTR_W = 6,
  parameter int IDX_W = 4,
  parameter int ROWS  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [PTR_W-1:0] sp_q,
  output logic [ROWS-1:0]  sel_q,
  output logic             crit_q
);
  localparam logic [PTR_W-1:0] P_ONE = PTR_W'(1);

  logic [PTR_W-1:0] sp_nx;
  logic [ROWS-1:0]  sel_nx;

  always_comb begin
    sp_nx = sp_q;
    if (step_up)      sp_nx = sp_q + P_ONE;
    else if (step_dn) sp_nx = sp_q - P_ONE;
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_dec
    assign sel_nx[g] = (sp_nx[IDX_W-1:0] == IDX_W'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      sel_q  <= '0;
      crit_q <= 1'b0;
    end else begin
      sp_q   <= sp_nx;
      sel_q  <= sel_nx;
      crit_q <= |sp_nx[PTR_W-1:IDX_W];
    end
  end
endmodule

// File: rtl/sstk_mem.sv
module sstk_mem #(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 4,
  parameter int ROWS   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_hi,
  input  logic              we_lo,
  input  logic [IDX_W-1:0]  wslot,
  input  logic [HALF_W-1:0] d_hi,
  input  logic [HALF_W-1:0] d_lo,
  input  logic [IDX_W-1:0]  rslot,
  output logic [HALF_W-1:0] q_hi,
  output logic [HALF_W-1:0] q_lo
);
  localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);

  logic [HALF_W-1:0] hi_arr [0:ROWS-1];
  logic [HALF_W-1:0] lo_arr [0:ROWS-1];
  logic [IDX_W-1:0]  widx, ridx;
  logic              wok, rok;

  assign widx = wslot - I_ONE;
  assign ridx = rslot - I_ONE;
  assign wok  = (wslot != '0);
  assign rok  = (rslot != '0);

  always_ff @(posedge clk) begin
    if (we_hi && wok) hi_arr[widx] <= d_hi;
  end

  always_ff @(posedge clk) begin
    if (we_lo && wok) lo_arr[widx] <= d_lo;
  end

  always_ff @(posedge clk) begin
    if (rst || !rok) begin
      q_hi <= '0;
      q_lo <= '0;
    end else begin
      q_hi <= hi_arr[ridx];
      q_lo <= lo_arr[ridx];
    end
  end
endmodule

// File: rtl/sstk_mover.sv
module sstk_mover
  import sstk_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_put,
  input  logic              start_take,
  input  logic [HALF_W-1:0] din,
  output logic              busy,
  output logic              late_we,
  output logic              late_dn,
  output logic [HALF_W-1:0] late_data
);
  sstk_mv_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= MV_IDLE;
    end else begin
      case (st)
        MV_IDLE: begin
          if (start_put)       st <= MV_PUT2;
          else if (start_take) st <= MV_TAKE2;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == MV_IDLE && start_put) late_data <= din;
  end

  assign busy    = (st != MV_IDLE);
  assign late_we = (st == MV_PUT2);
  assign late_dn = (st == MV_TAKE2);
endmodule

// File: rtl/sstk_top.sv
module sstk_top
  import sstk_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 4,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic              put_hi_i,
  input  logic              take_hi_i,
  input  logic              up_i,
  input  logic              down_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [HALF_W-1:0] hi_din_i,
  input  logic [HALF_W-1:0] lo_din_i,
  output logic [HALF_W-1:0] top_hi_o,
  output logic [HALF_W-1:0] top_lo_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic [(1<<IDX_W)-2:0] row_sel_o,
  output logic              crit_err_o
);
  localparam int ROWS = (1 << IDX_W) - 1;
  localparam logic [IDX_W-1:0] S_ONE = IDX_W'(1);

  sstk_op_t          op;
  logic              mv_busy, late_we, late_dn;
  logic [HALF_W-1:0] late_data;
  logic              step_up, step_dn;
  logic              we_hi, we_lo;
  logic [IDX_W-1:0]  cur_slot, wslot;
  logic [HALF_W-1:0] d_hi;

  always_comb begin
    op = OP_NONE;
    if (!mv_busy) begin
      if (push_i)                  op = OP_PUSH;
      else if (pull_i)             op = OP_PULL;
      else if (put_hi_i)           op = OP_PUT;
      else if (take_hi_i)          op = OP_TAKE;
      else if (up_i)               op = OP_UP;
      else if (down_i)             op = OP_DOWN;
      else if (wr_hi_i || wr_lo_i) op = OP_HALF;
    end
  end

  assign cur_slot = sp_o[IDX_W-1:0];
  assign step_up  = (op == OP_PUSH) || (op == OP_PUT) || (op == OP_UP);
  assign step_dn  = (op == OP_PULL) || (op == OP_DOWN) || late_dn;
  assign we_hi    = (op == OP_PUSH) || late_we || (op == OP_HALF && wr_hi_i);
  assign we_lo    = (op == OP_PUSH) || (op == OP_HALF && wr_lo_i);
  assign wslot    = (op == OP_PUSH) ? cur_slot + S_ONE : cur_slot;
  assign d_hi     = late_we ? late_data : hi_din_i;

  sstk_ptr #(.PTR_W(PTR_W), .IDX_W(IDX_W), .ROWS(ROWS)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .step_up (step_up),
    .step_dn (step_dn),
    .sp_q    (sp_o),
    .sel_q   (row_sel_o),
    .crit_q  (crit_err_o)
  );

  sstk_mem #(.HALF_W(HALF_W), .IDX_W(IDX_W), .ROWS(ROWS)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we_hi (we_hi),
    .we_lo (we_lo),
    .wslot (wslot),
    .d_hi  (d_hi),
    .d_lo  (lo_din_i),
    .rslot (cur_slot),
    .q_hi  (top_hi_o),
    .q_lo  (top_lo_o)
  );

  sstk_mover #(.HALF_W(HALF_W)) u_mover (
    .clk        (clk),
    .rst        (rst),
    .start_put  (op == OP_PUT),
    .start_take (op == OP_TAKE),
    .din        (hi_din_i),
    .busy       (mv_busy),
    .late_we    (late_we),
    .late_dn    (late_dn),
    .late_data  (late_data)
  );
endmodule

// File: rtl/sstk_chk.sv
module sstk_chk #(
  parameter int IDX_W = 4,
  parameter int PTR_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  push_i,
  input logic                  pull_i,
  input logic                  put_hi_i,
  input logic                  take_hi_i,
  input logic                  up_i,
  input logic                  down_i,
  input logic                  wr_hi_i,
  input logic                  wr_lo_i,
  input logic                  busy,
  input logic [PTR_W-1:0]      sp_o,
  input logic [(1<<IDX_W)-2:0] row_sel_o,
  input logic                  crit_err_o
);
  logic any_ptr_cmd;
  assign any_ptr_cmd = push_i | pull_i | put_hi_i | take_hi_i | up_i | down_i;

  // R1: the cycle after a reset edge shows the cleared pointer and error
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sp_o == '0 && !crit_err_o && row_sel_o == '0));

  // R2: error output tracks the flag bits of the pointer
  p_crit_flags_r2: assert property (@(posedge clk) disable iff (rst)
    crit_err_o == (sp_o[PTR_W-1] | sp_o[PTR_W-2]));

  // R3: an accepted push advances the pointer by one
  p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
    (push_i && !busy) |=> sp_o == $past(sp_o) + 6'd1);

  // R4: an accepted pull retreats the pointer by one
  p_pull_step_r4: assert property (@(posedge clk) disable iff (rst)
    (pull_i && !push_i && !busy) |=> sp_o == $past(sp_o) - 6'd1);

  // R5: at most one row selected, and none exactly when the index is zero
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel_o) && ((sp_o[IDX_W-1:0] == '0) == (row_sel_o == '0)));

  // R7: move into high half: step up, then hold the pointer
  p_put_timing_r7: assert property (@(posedge clk) disable iff (rst)
    (put_hi_i && !push_i && !pull_i && !busy)
      |=> (sp_o == $past(sp_o) + 6'd1) ##1 $stable(sp_o));

  // R8: move out of high half: hold the pointer, then step down
  p_take_timing_r8: assert property (@(posedge clk) disable iff (rst)
    (take_hi_i && !put_hi_i && !push_i && !pull_i && !busy)
      |=> $stable(sp_o) ##1 (sp_o == $past(sp_o) - 6'd1));

  // R9: half writes alone never move the pointer
  p_half_still_r9: assert property (@(posedge clk) disable iff (rst)
    ((wr_hi_i || wr_lo_i) && !any_ptr_cmd && !busy) |=> $stable(sp_o));

  // R10: push beats a simultaneous pull
  p_push_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (push_i && pull_i && !busy) |=> sp_o == $past(sp_o) + 6'd1);
endmodule

bind sstk_top sstk_chk #(.IDX_W(IDX_W), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .push_i     (push_i),
  .pull_i     (pull_i),
  .put_hi_i   (put_hi_i),
  .take_hi_i  (take_hi_i),
  .up_i       (up_i),
  .down_i     (down_i),
  .wr_hi_i    (wr_hi_i),
  .wr_lo_i    (wr_lo_i),
  .busy       (mv_busy),
  .sp_o       (sp_o),
  .row_sel_o  (row_sel_o),
  .crit_err_o (crit_err_o)
);

// File: tb/sstk_top_bench.sv
module sstk_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_i = 0, pull_i = 0, put_hi_i = 0, take_hi_i = 0;
  logic        up_i = 0, down_i = 0, wr_hi_i = 0, wr_lo_i = 0;
  logic [15:0] hi_din_i = 0, lo_din_i = 0;
  logic [15:0] top_hi_o, top_lo_o;
  logic [5:0]  sp_o;
  logic [14:0] row_sel_o;
  logic        crit_err_o;

  always #10 clk = ~clk;

  sstk_top u_sstk_top (
    .clk(clk), .rst(rst),
    .push_i(push_i), .pull_i(pull_i), .put_hi_i(put_hi_i), .take_hi_i(take_hi_i),
    .up_i(up_i), .down_i(down_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i),
    .hi_din_i(hi_din_i), .lo_din_i(lo_din_i),
    .top_hi_o(top_hi_o), .top_lo_o(top_lo_o), .sp_o(sp_o),
    .row_sel_o(row_sel_o), .crit_err_o(crit_err_o)
  );

  // reference model
  int          m_sp = 0, m_st = 0, slot = 0, nsp = 0;
  logic [15:0] m_lat = 0;
  logic [15:0] m_hi [15];
  logic [15:0] m_lo [15];
  bit          m_vh [15];
  bit          m_vl [15];
  logic [15:0] e_hi = 0, e_lo = 0;
  bit          e_hk = 1, e_lk = 1;

  always @(posedge clk) begin
    if (rst) begin
      m_sp = 0; m_st = 0; e_hi = 0; e_lo = 0; e_hk = 1; e_lk = 1;
      for (int i = 0; i < 15; i++) begin m_vh[i] = 0; m_vl[i] = 0; end
    end else begin
      slot = m_sp % 16;
      if (slot != 0) begin
        e_hi = m_hi[slot-1]; e_hk = m_vh[slot-1];
        e_lo = m_lo[slot-1]; e_lk = m_vl[slot-1];
      end else begin
        e_hi = 0; e_lo = 0; e_hk = 1; e_lk = 1;
      end
      if (m_st == 1) begin
        if (slot != 0) begin m_hi[slot-1] = m_lat; m_vh[slot-1] = 1; end
        m_st = 0;
      end else if (m_st == 2) begin
        m_sp = (m_sp + 63) % 64; m_st = 0;
      end else if (push_i) begin
        nsp = (m_sp + 1) % 64;
        if (nsp % 16 != 0) begin
          m_hi[nsp%16-1] = hi_din_i; m_vh[nsp%16-1] = 1;
          m_lo[nsp%16-1] = lo_din_i; m_vl[nsp%16-1] = 1;
        end
        m_sp = nsp;
      end else if (pull_i)    m_sp = (m_sp + 63) % 64;
      else if (put_hi_i) begin m_sp = (m_sp + 1) % 64; m_lat = hi_din_i; m_st = 1; end
      else if (take_hi_i)     m_st = 2;
      else if (up_i)          m_sp = (m_sp + 1) % 64;
      else if (down_i)        m_sp = (m_sp + 63) % 64;
      else if (slot != 0) begin
        if (wr_hi_i) begin m_hi[slot-1] = hi_din_i; m_vh[slot-1] = 1; end
        if (wr_lo_i) begin m_lo[slot-1] = lo_din_i; m_vl[slot-1] = 1; end
      end
    end
  end

  int    n_chk = 0, n_bad = 0;
  bit    chk_on = 0, done = 0;
  string phase = "R1";

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(phase, "sp", 32'(sp_o), 32'(m_sp));
      chk("R2", "crit", 32'(crit_err_o), 32'(m_sp >= 16));
      chk("R5", "sel", 32'(row_sel_o), (m_sp % 16 != 0) ? (32'd1 << (m_sp % 16 - 1)) : 32'd0);
      if (e_hk) chk(phase, "top_hi", 32'(top_hi_o), 32'(e_hi));
      if (e_lk) chk(phase, "top_lo", 32'(top_lo_o), 32'(e_lo));
    end
  end

  // bits: push pull put take up down wr_hi wr_lo
  task automatic step(input logic [7:0] m, input logic [15:0] h, input logic [15:0] l);
    @(negedge clk);
    {push_i, pull_i, put_hi_i, take_hi_i, up_i, down_i, wr_hi_i, wr_lo_i} = m;
    hi_din_i = h;
    lo_din_i = l;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    phase = "R1";
    step(8'h00, 0, 0);
    chk_on = 1;
    step(8'h80, 16'h1111, 16'h2222); // push under reset: no effect
    step(8'h00, 0, 0);
    rst = 1'b0;
    step(8'h00, 0, 0);
    phase = "R3";
    step(8'h80, 16'hA001, 16'hB001);
    step(8'h80, 16'hA002, 16'hB002);
    step(8'h80, 16'hA003, 16'hB003);
    phase = "R5";
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    phase = "R9";
    step(8'h01, 16'hDEAD, 16'hC0DE);
    step(8'h00, 0, 0);
    step(8'h02, 16'hBEEF, 16'hFFFF);
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    phase = "R4";
    step(8'h40, 0, 0);
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    phase = "R7";
    step(8'h20, 16'h7777, 16'h5555);
    step(8'h00, 16'h0BAD, 0);
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    phase = "R8";
    step(8'h10, 0, 0);
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    phase = "R6";
    step(8'h08, 16'h1234, 16'h5678);
    step(8'h04, 0, 0);
    step(8'h00, 0, 0);
    phase = "R10";
    step(8'hC0, 16'h4444, 16'h3333);
    step(8'h3F, 16'h9999, 16'h8888);
    step(8'h20, 16'h6666, 0);
    step(8'hFF, 16'h1357, 16'h2468);
    step(8'h10, 0, 0);
    step(8'h80, 16'hEEEE, 16'hEEEE);
    step(8'h00, 0, 0);
    phase = "R3";
    for (int i = 0; i < 16; i++) step(8'h80, 16'(i), 16'(i + 100));
    phase = "R2";
    step(8'h00, 0, 0);
    step(8'h08, 0, 0);
    step(8'h00, 0, 0);
    phase = "R4";
    for (int i = 0; i < 19; i++) step(8'h40, 0, 0);
    step(8'h00, 0, 0);
    step(8'h08, 0, 0);
    step(8'h00, 0, 0);
    phase = "R10";
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[3:0])
        4'd0, 4'd1, 4'd2: step(8'h80, lf, ~lf);
        4'd3, 4'd4:       step(8'h40, 0, 0);
        4'd5:             step(8'h20, lf ^ 16'h5A5A, 0);
        4'd6:             step(8'h10, 0, 0);
        4'd7:             step(8'h08, 0, 0);
        4'd8:             step(8'h04, 0, 0);
        4'd9:             step(8'h02, lf, 0);
        4'd10:            step(8'h01, 0, lf);
        4'd11:            step(8'h03, ~lf, lf);
        4'd12:            step(lf[15:8], lf, lf ^ 16'h0F0F);
        default:          step(8'h00, 0, 0);
      endcase
    end
    step(8'h00, 0, 0);
    step(8'h00, 0, 0);
    finish_run();
  end
endmodule